// File: doc/BRIEF.md
# Kasumi-Style FI Substitution Function

This block evaluates the 16-bit nonlinear FI mapping found inside each round of a Kasumi-style bulk cipher. A 16-bit data word and a 16-bit round subkey go in; a 16-bit word comes out. The data word is cut unevenly into a 9-bit upper part and a 7-bit lower part. Each part passes twice through a substitution box of its own width. The two parts are cross-mixed after every substitution, and the subkey is folded in between the two passes.

Words enter and leave over a valid/ready handshake. The parameter `PIPE` picks one of two builds. With `PIPE=0` the whole datapath is combinational and the handshake passes straight through. With `PIPE=1` a single register sits after the subkey mixing, which gives one cycle of latency and full throughput under back-pressure. Key scheduling and the surrounding round functions belong to other blocks.

Top module: `kfi_core`

## Requirements
- R1: The data word is split so that in_data[15:7] forms the 9-bit part N and in_data[6:0] forms the 7-bit part M.
- R2: A substitution stage first computes N' = S9(N) XOR {2'b00, M}, then M' = S7(M) XOR N'[6:0].
- R3: After the first stage, M is XORed with in_key[15:9] and N is XORed with in_key[8:0].
- R4: A second substitution stage, identical to the one in R2 and applied in the same order, follows the subkey mixing.
- R5: out_data places the final M in bits [15:9] and the final N in bits [8:0].
- R6: S7(x) is x cubed in GF(2^7) reduced by x^7+x+1, XOR 7'h2B; S9(x) is x to the fifth in GF(2^9) reduced by x^9+x^4+1, XOR 9'h0A5.
- R7: With PIPE=0, out_valid follows in_valid and in_ready follows out_ready in the same cycle, and out_data is the result for the current in_data and in_key.
- R8: With PIPE=1, the block holds one entry. in_ready is high whenever the entry is empty or out_ready is high. An accepted word's result appears on the next cycle. A presented result stays valid and unchanged while out_ready is low. Results leave in acceptance order, with none lost or repeated.
- R9: With PIPE=1, a synchronous active-high rst empties the entry, so that after reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | 16 | Data word to transform |
| in_key | input | 16 | Round subkey for this word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Transformed word |

## Verification
The assertions assume that the producer and consumer obey valid/ready rules. This means the consumer may drop out_ready at any cycle, and the block alone decides when a word is accepted. It also means in_data and in_key are sampled only on a cycle where in_valid and in_ready are both high. The stimulus drives valid and ready from independent random draws and changes data and key freely on cycles where no transfer happens. Every result is compared against a reference that rebuilds both substitution boxes from integer polynomial arithmetic.

// File: rtl/kfi_pkg.sv
`timescale 1ns/1ps
package kfi_pkg;
  localparam int SEVEN_W = 7;
  localparam int NINE_W  = 9;
  localparam int WORD_W  = SEVEN_W + NINE_W;
  localparam logic [SEVEN_W-1:0] POLY7_LOW = 7'h03;   // x^7 + x + 1
  localparam logic [NINE_W-1:0]  POLY9_LOW = 9'h011;  // x^9 + x^4 + 1
  localparam logic [SEVEN_W-1:0] AFF7      = 7'h2B;
  localparam logic [NINE_W-1:0]  AFF9      = 9'h0A5;

  function automatic logic [SEVEN_W-1:0] gf7_mul(input logic [SEVEN_W-1:0] a,
                                                 input logic [SEVEN_W-1:0] b);
    logic [SEVEN_W-1:0] acc;
    logic [SEVEN_W-1:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SEVEN_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SEVEN_W-1] ? ({x[SEVEN_W-2:0], 1'b0} ^ POLY7_LOW) : {x[SEVEN_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [NINE_W-1:0] gf9_mul(input logic [NINE_W-1:0] a,
                                                input logic [NINE_W-1:0] b);
    logic [NINE_W-1:0] acc;
    logic [NINE_W-1:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < NINE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[NINE_W-1] ? ({x[NINE_W-2:0], 1'b0} ^ POLY9_LOW) : {x[NINE_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [SEVEN_W-1:0] sbox7_f(input logic [SEVEN_W-1:0] x);
    return gf7_mul(gf7_mul(x, x), x) ^ AFF7;
  endfunction

  function automatic logic [NINE_W-1:0] sbox9_f(input logic [NINE_W-1:0] x);
    logic [NINE_W-1:0] sq;
    logic [NINE_W-1:0] qd;
    sq = gf9_mul(x, x);
    qd = gf9_mul(sq, sq);
    return gf9_mul(qd, x) ^ AFF9;
  endfunction
endpackage

// File: rtl/kfi_sbox.sv
`timescale 1ns/1ps
module kfi_sbox #(
  parameter int W = 7
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  generate
    if (W == kfi_pkg::SEVEN_W) begin : g_s7
      assign y = kfi_pkg::sbox7_f(x);
    end else begin : g_s9
      assign y = kfi_pkg::sbox9_f(x);
    end
  endgenerate
endmodule

// File: rtl/kfi_stage.sv
`timescale 1ns/1ps
module kfi_stage
  import kfi_pkg::*;
(
  input  logic [NINE_W-1:0]  nine_i,
  input  logic [SEVEN_W-1:0] seven_i,
  output logic [NINE_W-1:0]  nine_o,
  output logic [SEVEN_W-1:0] seven_o
);
  localparam int PAD_W = NINE_W - SEVEN_W;

  logic [NINE_W-1:0]  sub9;
  logic [SEVEN_W-1:0] sub7;

  kfi_sbox #(.W(NINE_W))  u_s9 (.x(nine_i),  .y(sub9));
  kfi_sbox #(.W(SEVEN_W)) u_s7 (.x(seven_i), .y(sub7));

  // The wide part is updated first; the narrow part uses the new value.
  assign nine_o  = sub9 ^ {{PAD_W{1'b0}}, seven_i};
  assign seven_o = sub7 ^ nine_o[SEVEN_W-1:0];
endmodule

// File: rtl/kfi_core.sv
`timescale 1ns/1ps
module kfi_core
  import kfi_pkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] in_key,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  // Stage one on the split input word
  logic [NINE_W-1:0]  s1_nine;
  logic [SEVEN_W-1:0] s1_seven;

  kfi_stage u_stage1 (
    .nine_i (in_data[WORD_W-1:SEVEN_W]),
    .seven_i(in_data[SEVEN_W-1:0]),
    .nine_o (s1_nine),
    .seven_o(s1_seven)
  );

  // Subkey folding: high key bits into the narrow part, low into the wide
  logic [NINE_W-1:0]  mix_nine;
  logic [SEVEN_W-1:0] mix_seven;
  assign mix_seven = s1_seven ^ in_key[WORD_W-1:NINE_W];
  assign mix_nine  = s1_nine  ^ in_key[NINE_W-1:0];

  // Named handshake events, visible to the checker
  logic fire_in;
  logic fire_out;
  assign fire_in  = in_valid  & in_ready;
  assign fire_out = out_valid & out_ready;

  logic [NINE_W-1:0]  st_nine;
  logic [SEVEN_W-1:0] st_seven;

  generate
    if (PIPE != 0) begin : g_reg
      logic               held_v;
      logic [NINE_W-1:0]  held_nine;
      logic [SEVEN_W-1:0] held_seven;

      always_ff @(posedge clk) begin
        if (rst) begin
          held_v <= 1'b0;
        end else if (fire_in) begin
          held_v <= 1'b1;
        end else if (out_ready) begin
          held_v <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (fire_in) begin
          held_nine  <= mix_nine;
          held_seven <= mix_seven;
        end
      end

      assign in_ready  = ~held_v | out_ready;
      assign out_valid = held_v;
      assign st_nine   = held_nine;
      assign st_seven  = held_seven;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign st_nine   = mix_nine;
      assign st_seven  = mix_seven;
    end
  endgenerate

  // Stage two repeats the same substitution order
  logic [NINE_W-1:0]  s2_nine;
  logic [SEVEN_W-1:0] s2_seven;

  kfi_stage u_stage2 (
    .nine_i (st_nine),
    .seven_i(st_seven),
    .nine_o (s2_nine),
    .seven_o(s2_seven)
  );

  assign out_data = {s2_seven, s2_nine};
endmodule

// File: rtl/kfi_core_chk.sv
`timescale 1ns/1ps
module kfi_core_chk #(
  parameter int PIPE = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        fire_in
);
  generate
    if (PIPE != 0) begin : g_reg
      logic seen_accept;
      always_ff @(posedge clk) begin
        if (rst) seen_accept <= 1'b0;
        else if (fire_in) seen_accept <= 1'b1;
      end

      // R9: nothing is presented before a word was ever accepted
      a_r9_no_phantom: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> seen_accept);

      // R8: a stalled result stays valid and unchanged
      a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      // R8: an empty entry always takes input
      a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

      // R8: an accepted word is presented on the next cycle
      a_r8_accept_presents: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_comb
      // R7: results exist only alongside an input word
      a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_valid);

      // R7: a ready consumer lets the input through
      a_r7_ready_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_ready) |-> in_ready);
    end
  endgenerate
endmodule

bind kfi_core kfi_core_chk #(.PIPE(PIPE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .fire_in  (fire_in)
);

// File: tb/tb_kfi_core.sv
`timescale 1ns/1ps
module tb_kfi_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic [15:0] in_key = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;
  logic        c_in_ready, c_out_valid;
  logic [15:0] c_out_data;

  kfi_core #(.PIPE(1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  kfi_core #(.PIPE(0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_data(in_data), .in_key(in_key), .out_valid(c_out_valid),
    .out_ready(out_ready), .out_data(c_out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int s7_t[128];
  int s9_t[512];
  logic [15:0] expq[$];
  bit          prev_stall = 1'b0;
  logic [15:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Carry-less product followed by long-division reduction
  function automatic int polymul(input int a, input int b, input int w, input int poly);
    int p = 0;
    for (int i = 0; i < w; i++) if ((b >> i) & 1) p = p ^ (a << i);
    for (int bit_i = 2*w-2; bit_i >= w; bit_i--)
      if ((p >> bit_i) & 1) p = p ^ (poly << (bit_i - w));
    return p;
  endfunction

  function automatic int powm(input int x, input int e, input int w, input int poly);
    int r = 1;
    for (int i = 0; i < e; i++) r = polymul(r, x, w, poly);
    return r;
  endfunction

  // R1..R5 restated on integers
  function automatic logic [15:0] ref_fi(input int d, input int k);
    int n, m;
    n = (d >> 7) & 'h1FF;
    m = d & 'h7F;
    n = s9_t[n] ^ m;
    m = s7_t[m] ^ (n & 'h7F);
    m = m ^ ((k >> 9) & 'h7F);
    n = n ^ (k & 'h1FF);
    n = s9_t[n] ^ m;
    m = s7_t[m] ^ (n & 'h7F);
    return 16'((m << 9) | n);
  endfunction

  // One cycle: drive at negedge, evaluate the coming edge's transfers
  task automatic step(input bit v, input logic [15:0] d, input logic [15:0] k,
                      input bit rdy, input string tag);
    @(negedge clk);
    in_valid = v; in_data = d; in_key = k; out_ready = rdy;
    #1;
    // combinational build (R7)
    chk(c_out_valid == v, "R7 out_valid", int'(c_out_valid), int'(v));
    chk(c_in_ready == rdy, "R7 in_ready", int'(c_in_ready), int'(rdy));
    if (v) chk(c_out_data == ref_fi(d, k), tag, int'(c_out_data), int'(ref_fi(d, k)));
    // registered build (R8)
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R8 stalled result held",
          int'(out_data), int'(prev_data));
    if (!out_valid) chk(in_ready == 1'b1, "R8 ready when empty", int'(in_ready), 1);
    if (out_valid && rdy) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected result", int'(out_data), 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R8 ordered result", int'(out_data), int'(e));
      end
    end
    if (v && in_ready) expq.push_back(ref_fi(d, k));
    prev_stall = out_valid && !rdy;
    prev_data  = out_data;
  endtask

  initial begin
    for (int x = 0; x < 128; x++) s7_t[x] = powm(x, 3, 7, 'h83) ^ 'h2B;
    for (int x = 0; x < 512; x++) s9_t[x] = powm(x, 5, 9, 'h211) ^ 'hA5;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: empty after reset
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

    // R6: all-zero word exposes the affine constants of both boxes
    step(1, 16'h0000, 16'h0000, 1, "R6 zero word");
    // R1: each part isolated
    step(1, 16'hFF80, 16'h0000, 1, "R1 wide part only");
    step(1, 16'h007F, 16'h0000, 1, "R1 narrow part only");
    step(1, 16'h8001, 16'h0000, 1, "R1 boundary bits");
    // R3: each key field isolated
    step(1, 16'h1234, 16'hFE00, 1, "R3 key high field");
    step(1, 16'h1234, 16'h01FF, 1, "R3 key low field");
    step(1, 16'hFFFF, 16'hFFFF, 1, "R2/R4/R5 all ones");
    // R8: stall with a held result, then release
    step(1, 16'hA5A5, 16'h5A5A, 0, "R2/R4/R5 stall entry");
    step(1, 16'h0F0F, 16'h3C3C, 0, "R8 blocked input");
    step(0, 16'h0000, 16'h0000, 0, "R8 idle stall");
    step(1, 16'h0F0F, 16'h3C3C, 1, "R8 release");
    step(0, 16'h0000, 16'h0000, 1, "R8 drain");

    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 16'($urandom), 16'($urandom),
           ($urandom % 3) != 0, "R2/R4/R5 random");
    for (int i = 0; i < 4; i++) step(0, 16'h0000, 16'h0000, 1, "R8 drain");
    chk(expq.size() == 0, "R8 nothing lost", expq.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule